// File: doc/BRIEF.md
# Configuration Space Access Bridge

This block gives a host processor indirect access to the configuration registers of the functions on one local bus through two small I/O locations. Software first writes a 32-bit selector into the address location, naming an enable bit, a bus, a device/function and a register. Any later access to the 4-byte data location is turned into a single configuration request to the chosen function, or is answered locally with all-ones when it cannot be delivered.

The host side is a simple request/acknowledge port. `io_off_i[2]` selects the location: 0 is the address register and 1 is the data window. `io_off_i[1:0]` is the byte offset inside the location. The size code is 2'b00 for a byte, 2'b01 for a word, and 2'b1x for a dword. Each function has a present flag and its own request strobe and acknowledge. The register number, size, direction, devfn and write data travel on shared lines. Read data comes back right-aligned. The host must wait for `io_ack_o` before it issues the next request.

Top module: `cfgb_bridge`

## Requirements
- R1: After reset the address register reads as 0, so config cycles are disabled, and no downstream strobe is raised.
- R2: A dword write to the address location latches all 32 bits, and a dword read returns them unchanged. A byte or word write there leaves the register unchanged, and a byte or word read returns 0xFF or 0xFFFF.
- R3: A data-window access while address bit 31 is 0 returns all-ones matched to the size (0xFF, 0xFFFF, 0xFFFFFFFF) on a read, and causes no downstream request.
- R4: A data-window access whose bus field (address bits 23:16) differs from OWN_BUS (0) behaves as in R3.
- R5: A data-window access whose devfn field (address bits 15:8) is NUM_FN or above, or names a function whose present flag is 0, behaves as in R3.
- R6: For a dword data access, the forwarded register number is address bits 7:2 followed by 2'b00, whatever the port byte offset.
- R7: For a byte or word data access, the forwarded register number is address bits 7:0 bitwise-ORed with the port byte offset.
- R8: Each delivered data-window access raises exactly one one-cycle strobe, only on the target's `cfg_req_o` bit. The strobe carries the direction, the 8-bit devfn, the size code and the write data unchanged.
- R9: Read data from a delivered access is the target's response masked to the access size, with the upper bits zero.
- R10: `io_ack_o` is a one-cycle pulse. A local answer comes one cycle after the request; a delivered access is answered one cycle after the target acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_req_i | input | 1 | Host access strobe, one cycle |
| io_we_i | input | 1 | 1 = write, 0 = read |
| io_off_i | input | 3 | Bit 2: 0 address register, 1 data window; bits 1:0 byte offset |
| io_size_i | input | 2 | 00 byte, 01 word, 1x dword |
| io_wdata_i | input | 32 | Host write data, right-aligned |
| io_ack_o | output | 1 | Access complete |
| io_rdata_o | output | 32 | Read data, valid with io_ack_o |
| fn_present_i | input | NUM_FN | Present flag per function |
| cfg_req_o | output | NUM_FN | Request strobe per function |
| cfg_we_o | output | 1 | Request direction |
| cfg_devfn_o | output | 8 | Device/function number |
| cfg_reg_o | output | 8 | Register number |
| cfg_size_o | output | 2 | Size code |
| cfg_wdata_o | output | 32 | Write data |
| cfg_ack_i | input | NUM_FN | Acknowledge per function |
| cfg_rdata_i | input | 32*NUM_FN | Read data per function |

## Verification
The bench sweeps enable, bus, every devfn up to two past the function count, every size, every port offset, all four low register bits, and both directions. An absent function, a foreign bus and a cleared enable each appear in that sweep.
- A design that added the port offset instead of ORing it would forward the wrong register when the low bits overlap.
- A design that kept the offset on dword accesses would break the alignment rule.
- A design that leaked a request on a rejected access would show an extra strobe.
- A design that returned unmasked data would show upper bits set on narrow reads.

The bench also times every acknowledge, and checks that narrow writes cannot corrupt the address register.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} cfgb_state_e;

  // all-ones value matched to access size
  function automatic logic [31:0] size_ones(input logic [1:0] sz);
    if (sz[1])      return 32'hFFFF_FFFF;
    else if (sz[0]) return 32'h0000_FFFF;
    else            return 32'h0000_00FF;
  endfunction
endpackage

// File: rtl/cfgb_decode.sv
module cfgb_decode #(
  parameter int NUM_FN  = 4,
  parameter int OWN_BUS = 0,
  parameter int FN_W    = 2
) (
  input  logic              en_i,
  input  logic [7:0]        bus_i,
  input  logic [7:0]        devfn_i,
  input  logic [7:0]        reg_i,
  input  logic [1:0]        off_i,
  input  logic [1:0]        size_i,
  input  logic [NUM_FN-1:0] present_i,
  output logic              hit_o,
  output logic [FN_W-1:0]   fn_o,
  output logic [7:0]        reg_o
);
  logic in_range;

  always_comb begin
    fn_o     = devfn_i[FN_W-1:0];
    in_range = (devfn_i < 8'(NUM_FN));
    hit_o    = en_i && (bus_i == 8'(OWN_BUS)) && in_range && present_i[fn_o];
    // dword forces alignment, narrow merges byte offset
    reg_o    = size_i[1] ? {reg_i[7:2], 2'b00} : (reg_i | {6'b0, off_i});
  end
endmodule

// File: rtl/cfgb_rsp_sel.sv
module cfgb_rsp_sel #(
  parameter int NUM_FN = 4,
  parameter int FN_W   = 2
) (
  input  logic [NUM_FN*32-1:0] rdata_i,
  input  logic [NUM_FN-1:0]    ack_i,
  input  logic [FN_W-1:0]      sel_i,
  output logic [31:0]          rdata_o,
  output logic                 ack_o
);
  logic [31:0] lane [NUM_FN];

  for (genvar g = 0; g < NUM_FN; g++) begin : g_lane
    assign lane[g] = rdata_i[g*32 +: 32];
  end

  assign rdata_o = lane[sel_i];
  assign ack_o   = ack_i[sel_i];
endmodule

// File: rtl/cfgb_bridge.sv
module cfgb_bridge
  import cfgb_pkg::*;
#(
  parameter int NUM_FN  = 4,
  parameter int OWN_BUS = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 io_req_i,
  input  logic                 io_we_i,
  input  logic [2:0]           io_off_i,
  input  logic [1:0]           io_size_i,
  input  logic [31:0]          io_wdata_i,
  output logic                 io_ack_o,
  output logic [31:0]          io_rdata_o,
  input  logic [NUM_FN-1:0]    fn_present_i,
  output logic [NUM_FN-1:0]    cfg_req_o,
  output logic                 cfg_we_o,
  output logic [7:0]           cfg_devfn_o,
  output logic [7:0]           cfg_reg_o,
  output logic [1:0]           cfg_size_o,
  output logic [31:0]          cfg_wdata_o,
  input  logic [NUM_FN-1:0]    cfg_ack_i,
  input  logic [NUM_FN*32-1:0] cfg_rdata_i
);
  localparam int FN_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1;

  cfgb_state_e       st_q;
  logic [31:0]       addr_q, rdata_q, wdata_q;
  logic              ack_q, we_q;
  logic [NUM_FN-1:0] req_q;
  logic [7:0]        devfn_q, reg_q;
  logic [1:0]        size_q;
  logic [FN_W-1:0]   sel_q;

  logic              hit;
  logic [FN_W-1:0]   fn;
  logic [7:0]        dec_reg;
  logic [31:0]       rsp_data;
  logic              rsp_ack;

  cfgb_decode #(.NUM_FN(NUM_FN), .OWN_BUS(OWN_BUS), .FN_W(FN_W)) u_dec (
    .en_i     (addr_q[31]),
    .bus_i    (addr_q[23:16]),
    .devfn_i  (addr_q[15:8]),
    .reg_i    (addr_q[7:0]),
    .off_i    (io_off_i[1:0]),
    .size_i   (io_size_i),
    .present_i(fn_present_i),
    .hit_o    (hit),
    .fn_o     (fn),
    .reg_o    (dec_reg)
  );

  cfgb_rsp_sel #(.NUM_FN(NUM_FN), .FN_W(FN_W)) u_rsp (
    .rdata_i(cfg_rdata_i),
    .ack_i  (cfg_ack_i),
    .sel_i  (sel_q),
    .rdata_o(rsp_data),
    .ack_o  (rsp_ack)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      rdata_q <= '0;
      wdata_q <= '0;
      ack_q   <= 1'b0;
      we_q    <= 1'b0;
      req_q   <= '0;
      devfn_q <= '0;
      reg_q   <= '0;
      size_q  <= '0;
      sel_q   <= '0;
    end else begin
      ack_q <= 1'b0;
      req_q <= '0;
      case (st_q)
        ST_IDLE: if (io_req_i) begin
          if (!io_off_i[2]) begin
            if (io_we_i && io_size_i[1]) addr_q <= io_wdata_i;
            rdata_q <= io_size_i[1] ? addr_q : size_ones(io_size_i);
            ack_q   <= 1'b1;
          end else if (!hit) begin
            rdata_q <= size_ones(io_size_i);
            ack_q   <= 1'b1;
          end else begin
            req_q   <= {{(NUM_FN-1){1'b0}}, 1'b1} << fn;
            we_q    <= io_we_i;
            devfn_q <= addr_q[15:8];
            reg_q   <= dec_reg;
            size_q  <= io_size_i;
            wdata_q <= io_wdata_i;
            sel_q   <= fn;
            st_q    <= ST_WAIT;
          end
        end
        ST_WAIT: if (rsp_ack) begin
          rdata_q <= rsp_data & size_ones(size_q);
          ack_q   <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign io_ack_o    = ack_q;
  assign io_rdata_o  = rdata_q;
  assign cfg_req_o   = req_q;
  assign cfg_we_o    = we_q;
  assign cfg_devfn_o = devfn_q;
  assign cfg_reg_o   = reg_q;
  assign cfg_size_o  = size_q;
  assign cfg_wdata_o = wdata_q;

  a_r8_req_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_req_o));
  a_r8_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cfg_req_o) |=> !(|cfg_req_o));
  a_r10_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ack_o |=> !io_ack_o);
  a_r6_dword_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|cfg_req_o) && cfg_size_o[1]) |-> (cfg_reg_o[1:0] == 2'b00));
  a_r3_req_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cfg_req_o) |-> addr_q[31]);
  a_r4_req_own_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cfg_req_o) |-> (addr_q[23:16] == 8'(OWN_BUS)));
  a_r5_req_devfn_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cfg_req_o) |-> (cfg_devfn_o == addr_q[15:8]));
endmodule

// File: tb/cfgb_bridge_test.sv
`timescale 1ns/1ps
module cfgb_bridge_test;
  localparam int NFN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             io_req = 1'b0, io_we = 1'b0;
  logic [2:0]       io_off = '0;
  logic [1:0]       io_size = '0;
  logic [31:0]      io_wdata = '0;
  logic             io_ack;
  logic [31:0]      io_rdata;
  logic [NFN-1:0]   present = 4'b1011;
  logic [NFN-1:0]   cfg_req;
  logic             cfg_we;
  logic [7:0]       cfg_devfn, cfg_reg;
  logic [1:0]       cfg_size;
  logic [31:0]      cfg_wdata;
  logic [NFN-1:0]   cfg_ack = '0;
  logic [NFN*32-1:0] cfg_rdata = '0;

  cfgb_bridge #(.NUM_FN(NFN), .OWN_BUS(0)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .io_req_i(io_req), .io_we_i(io_we), .io_off_i(io_off), .io_size_i(io_size),
    .io_wdata_i(io_wdata), .io_ack_o(io_ack), .io_rdata_o(io_rdata),
    .fn_present_i(present), .cfg_req_o(cfg_req), .cfg_we_o(cfg_we),
    .cfg_devfn_o(cfg_devfn), .cfg_reg_o(cfg_reg), .cfg_size_o(cfg_size),
    .cfg_wdata_o(cfg_wdata), .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata)
  );

  int checks = 0, fails = 0, cyc = 0;
  int cap_cnt = 0;
  logic [NFN-1:0] cap_req;
  logic cap_we;
  logic [7:0] cap_devfn, cap_reg;
  logic [1:0] cap_size;
  logic [31:0] cap_wdata;
  logic pend = 1'b0;
  int pend_fn = 0;

  function automatic logic [31:0] tdata(input int f, input logic [7:0] r);
    return {8'(f*16+3), r ^ 8'h5A, 8'hC3, r};
  endfunction

  function automatic logic [31:0] ones(input logic [1:0] sz);
    return sz[1] ? 32'hFFFF_FFFF : (sz[0] ? 32'h0000_FFFF : 32'h0000_00FF);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // target model: capture strobe, acknowledge on the following negedge
  always @(negedge clk) begin
    cfg_ack = '0;
    if (pend) begin
      cfg_ack[pend_fn] = 1'b1;
      pend = 1'b0;
    end
    if (|cfg_req) begin
      cap_cnt++;
      cap_req = cfg_req; cap_we = cfg_we; cap_devfn = cfg_devfn;
      cap_reg = cfg_reg; cap_size = cfg_size; cap_wdata = cfg_wdata;
      for (int f = 0; f < NFN; f++) begin
        if (cfg_req[f]) pend_fn = f;
        cfg_rdata[f*32 +: 32] = tdata(f, cfg_reg);
      end
      pend = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic io(input logic we, input logic [2:0] off, input logic [1:0] sz,
                    input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    chk(!io_ack, "R10 ack not held", {31'b0, io_ack}, 32'h0);
    io_req = 1'b1; io_we = we; io_off = off; io_size = sz; io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    lat = 0;
    while (!io_ack && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    if (!io_ack) chk(1'b0, "R10 no ack", 32'h0, 32'h1);
    rd = io_rdata;
  endtask

  initial begin
    logic [31:0] rd, a, wd;
    int lat, n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(cfg_req == '0, "R1 no strobe", {28'b0, cfg_req}, 32'h0);
    io(1'b0, 3'b000, 2'b10, 32'h0, rd, lat);
    chk(rd == 32'h0, "R1 addr reset", rd, 32'h0);
    n0 = cap_cnt;
    io(1'b0, 3'b100, 2'b10, 32'h0, rd, lat);
    chk(rd == 32'hFFFF_FFFF, "R1 disabled read", rd, 32'hFFFF_FFFF);
    chk(cap_cnt == n0, "R1 no request", cap_cnt, n0);

    // R2: narrow address accesses
    io(1'b1, 3'b000, 2'b10, 32'h8000_0104, rd, lat);
    chk(lat == 0, "R10 local latency", lat, 0);
    io(1'b1, 3'b000, 2'b00, 32'h0000_0077, rd, lat);
    io(1'b1, 3'b000, 2'b01, 32'h0000_7777, rd, lat);
    io(1'b0, 3'b000, 2'b10, 32'h0, rd, lat);
    chk(rd == 32'h8000_0104, "R2 narrow write ignored", rd, 32'h8000_0104);
    io(1'b0, 3'b000, 2'b00, 32'h0, rd, lat);
    chk(rd == 32'hFF, "R2 byte read", rd, 32'hFF);
    io(1'b0, 3'b000, 2'b01, 32'h0, rd, lat);
    chk(rd == 32'hFFFF, "R2 word read", rd, 32'hFFFF);

    for (int en = 0; en < 2; en++)
      for (int bi = 0; bi < 2; bi++)
        for (int d = 0; d < 6; d++)
          for (int lo = 0; lo < 4; lo++) begin
            logic [7:0] bus, r;
            bus = bi[0] ? 8'd3 : 8'd0;
            r = 8'(d*16 + 8 + lo);
            a = {en[0], 7'b0, bus, 8'(d), r};
            io(1'b1, 3'b000, 2'b10, a, rd, lat);
            io(1'b0, 3'b000, 2'b10, 32'h0, rd, lat);
            chk(rd == a, "R2 addr readback", rd, a);
            for (int sz = 0; sz < 3; sz++)
              for (int off = 0; off < 4; off++)
                for (int w = 0; w < 2; w++) begin
                  logic hit;
                  logic [7:0] ereg;
                  logic [31:0] exp;
                  string why;
                  hit = en[0] && bus == 8'd0 && d < NFN && present[d % NFN];
                  why = !en[0] ? "R3" : (bus != 8'd0 ? "R4" : (hit ? "R8" : "R5"));
                  ereg = (sz == 2) ? {r[7:2], 2'b00} : (r | 8'(off));
                  wd = {8'(d), r, 8'(off), 8'(sz*16 + w)};
                  n0 = cap_cnt;
                  io(w[0], {1'b1, 2'(off)}, 2'(sz), wd, rd, lat);
                  chk(cap_cnt == n0 + (hit ? 1 : 0), {why, " request count"}, cap_cnt - n0, hit ? 1 : 0);
                  chk(lat == (hit ? 2 : 0), "R10 latency", lat, hit ? 2 : 0);
                  if (hit) begin
                    chk(cap_reg == ereg, (sz == 2) ? "R6 dword reg" : "R7 narrow reg", cap_reg, ereg);
                    chk(cap_req == 4'(1 << d), "R8 strobe target", cap_req, 4'(1 << d));
                    chk(cap_devfn == 8'(d), "R8 devfn", cap_devfn, d);
                    chk(cap_size == 2'(sz), "R8 size", cap_size, sz);
                    chk(cap_we == w[0], "R8 direction", cap_we, w);
                    if (w[0]) chk(cap_wdata == wd, "R8 wdata", cap_wdata, wd);
                    else begin
                      exp = tdata(d, ereg) & ones(2'(sz));
                      chk(rd == exp, "R9 read data", rd, exp);
                    end
                  end else if (!w[0]) begin
                    exp = ones(2'(sz));
                    chk(rd == exp, {why, " all-ones"}, rd, exp);
                  end
                end
          end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule